// File: doc/BRIEF.md
# Serial-Configured Fault Saboteur Array

This block sits on a bundle of internal datapath wires and can corrupt any of them on command. Each wire passes through its own saboteur cell. A cell either forwards its input unchanged or replaces it with a fault. The fault can force the wire to 0, force it to 1, or invert it for a single clock cycle. Each output goes through a register, so every output lags its input by one clock.

Fault settings reach the cells only through a serial scan path. Every cell holds a three-bit shadow register, and all the shadow registers are linked into one long shift register. A controller first shifts a complete configuration into this chain. It then pulses an update strobe, which copies every shadow register into the working configuration in the same cycle. Shifting never disturbs the working configuration, so the outputs stay clean while a new campaign is being loaded. A global fault-enable gates every fault at once. The scan output carries the far end of the chain, so several arrays can be daisy-chained and the loaded contents can be read back.

Top module: `sab_chain`

## Requirements
- R1: A synchronous active-high reset clears every shadow register, every working configuration, the registered outputs and the enable history. After reset, `data_out` and `scan_out` read 0, and with the global enable high every wire passes through.
- R2: While `shift_en` is high, each clock moves the whole chain one place. `scan_in` enters the chain at cell 0, and `scan_out` then shows the bit that sat one place behind the end of the chain. Each cell takes three bits in the order arm, mode[1], mode[0]. The first triple shifted in ends up in the cell with the highest index after 3·N shifts. Once loaded, `scan_out` presents the shifted bits again in their original order.
- R3: While `shift_en` is low, the chain holds its contents and `scan_out` does not change, whatever `scan_in` does.
- R4: Shifting alone never changes `data_out`. A pulse on `update` copies every shadow register into the working configuration at that clock edge. The outputs follow the new configuration from the next edge on.
- R5: While `fault_en` is low, `data_out` equals the `data_in` sampled one clock earlier, whatever the configuration.
- R6: A cell whose arm bit is 0, or whose mode is 00, passes its input through even while `fault_en` is high.
- R7: An armed cell with mode 01 drives 0 for as long as `fault_en` stays high.
- R8: An armed cell with mode 10 drives 1 for as long as `fault_en` stays high.
- R9: An armed cell with mode 11 inverts its input only on the first clock at which `fault_en` is sampled high after being low. It passes its input through on every later clock with the enable high. Each new rising edge of the enable fires the fault again.
- R10: Cells act independently. One loaded configuration can hold different modes in different cells, and each wire shows only its own fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_in | input | 1 | Serial configuration input, enters cell 0 |
| shift_en | input | 1 | Advances the configuration chain by one bit |
| update | input | 1 | Copies all shadow registers into the working configuration |
| fault_en | input | 1 | Global fault enable |
| data_in | input | N_SIG | Functional signals from the datapath |
| data_out | output | N_SIG | Registered, possibly faulted, signals |
| scan_out | output | 1 | Far end of the chain, used for readback or cascading |

## Verification
A shadow register that has lost a bit, or has picked one up, shows at `scan_out` during readback: the wrong bit appears at the exact step whose position matches its place in the chain. A fault in the working configuration shows on `data_out` one clock after the enable is sampled high, and only on the affected wire. A transient that never clears, or that fires twice, shows on the second enabled clock. A broken edge history shows when the enable rises for the second time.

// File: rtl/sab_pkg.sv
package sab_pkg;

  localparam int CFG_W = 3;

  typedef enum logic [1:0] {
    MODE_PASS = 2'b00,
    MODE_SA0  = 2'b01,
    MODE_SA1  = 2'b10,
    MODE_FLIP = 2'b11
  } sab_mode_e;

  typedef struct packed {
    logic      arm;
    sab_mode_e mode;
  } sab_cfg_t;

endpackage

// File: rtl/sab_en_edge.sv
module sab_en_edge (
  input  logic clk,
  input  logic rst,
  input  logic fault_en,
  output logic en_rise
);

  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= fault_en;
  end

  assign en_rise = fault_en & ~en_q;

endmodule

// File: rtl/sab_cell.sv
module sab_cell
  import sab_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sin,
  input  logic             shift_en,
  input  logic             update,
  input  logic             fault_en,
  input  logic             en_rise,
  input  logic             d_in,
  output logic             d_out,
  output logic             sout,
  output logic [CFG_W-1:0] shadow_o,
  output logic [CFG_W-1:0] active_o
);

  sab_cfg_t shadow_q;
  sab_cfg_t active_q;
  logic     d_next;

  // serial shadow: arm ends in the top bit after three shifts
  always_ff @(posedge clk) begin
    if (rst)           shadow_q <= '0;
    else if (shift_en) shadow_q <= sab_cfg_t'({shadow_q[CFG_W-2:0], sin});
  end

  always_ff @(posedge clk) begin
    if (rst)         active_q <= '0;
    else if (update) active_q <= shadow_q;
  end

  always_comb begin
    d_next = d_in;
    if (fault_en && active_q.arm) begin
      unique case (active_q.mode)
        MODE_SA0:  d_next = 1'b0;
        MODE_SA1:  d_next = 1'b1;
        MODE_FLIP: d_next = en_rise ? ~d_in : d_in;
        default:   d_next = d_in;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) d_out <= 1'b0;
    else     d_out <= d_next;
  end

  assign sout     = shadow_q.arm;
  assign shadow_o = shadow_q;
  assign active_o = active_q;

endmodule

// File: rtl/sab_chain.sv
module sab_chain
  import sab_pkg::*;
#(
  parameter int N_SIG = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_in,
  input  logic             shift_en,
  input  logic             update,
  input  logic             fault_en,
  input  logic [N_SIG-1:0] data_in,
  output logic [N_SIG-1:0] data_out,
  output logic             scan_out
);

  localparam int CHAIN_W = CFG_W * N_SIG;

  logic               en_rise;
  logic [N_SIG:0]     link;
  logic [CHAIN_W-1:0] shadow_flat;
  logic [CHAIN_W-1:0] active_flat;

  sab_en_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .fault_en (fault_en),
    .en_rise  (en_rise)
  );

  assign link[0] = scan_in;

  for (genvar i = 0; i < N_SIG; i++) begin : g_cell
    sab_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .sin      (link[i]),
      .shift_en (shift_en),
      .update   (update),
      .fault_en (fault_en),
      .en_rise  (en_rise),
      .d_in     (data_in[i]),
      .d_out    (data_out[i]),
      .sout     (link[i+1]),
      .shadow_o (shadow_flat[CFG_W*i +: CFG_W]),
      .active_o (active_flat[CFG_W*i +: CFG_W])
    );
  end

  assign scan_out = link[N_SIG];

endmodule

// File: rtl/sab_chain_chk.sv
module sab_chain_chk
  import sab_pkg::*;
#(
  parameter int N_SIG = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   shift_en,
  input logic                   update,
  input logic                   fault_en,
  input logic [N_SIG-1:0]       data_in,
  input logic [N_SIG-1:0]       data_out,
  input logic                   scan_out,
  input logic                   next_bit,
  input logic [CFG_W*N_SIG-1:0] active_flat
);

  logic [N_SIG-1:0] sa0_m, sa1_m, flip_m, idle_m;
  logic             prev_en;

  always_comb begin
    for (int i = 0; i < N_SIG; i++) begin
      sa0_m[i]  = active_flat[CFG_W*i+2] && (active_flat[CFG_W*i +: 2] == 2'b01);
      sa1_m[i]  = active_flat[CFG_W*i+2] && (active_flat[CFG_W*i +: 2] == 2'b10);
      flip_m[i] = active_flat[CFG_W*i+2] && (active_flat[CFG_W*i +: 2] == 2'b11);
    end
    idle_m = ~(sa0_m | sa1_m | flip_m);
  end

  always_ff @(posedge clk) begin
    if (rst) prev_en <= 1'b0;
    else     prev_en <= fault_en;
  end

  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> scan_out == $past(next_bit));

  p_scan_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(scan_out));

  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !update |=> $stable(active_flat));

  p_passthru_r5: assert property (@(posedge clk) disable iff (rst)
    !fault_en |=> data_out == $past(data_in));

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    fault_en |=> ((data_out ^ $past(data_in)) & $past(idle_m)) == '0);

  p_sa0_r7: assert property (@(posedge clk) disable iff (rst)
    fault_en |=> (data_out & $past(sa0_m)) == '0);

  p_sa1_r8: assert property (@(posedge clk) disable iff (rst)
    fault_en |=> (data_out & $past(sa1_m)) == $past(sa1_m));

  p_flip_rise_r9: assert property (@(posedge clk) disable iff (rst)
    (fault_en && !prev_en) |=>
      ((data_out ^ $past(data_in)) & $past(flip_m)) == $past(flip_m));

  p_flip_once_r9: assert property (@(posedge clk) disable iff (rst)
    (fault_en && prev_en) |=> ((data_out ^ $past(data_in)) & $past(flip_m)) == '0);

endmodule

bind sab_chain sab_chain_chk #(.N_SIG(N_SIG)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .shift_en    (shift_en),
  .update      (update),
  .fault_en    (fault_en),
  .data_in     (data_in),
  .data_out    (data_out),
  .scan_out    (scan_out),
  .next_bit    (shadow_flat[CHAIN_W-2]),
  .active_flat (active_flat)
);

// File: tb/test_sab_chain.sv
module test_sab_chain;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         scan_in = 1'b0;
  logic         shift_en = 1'b0;
  logic         update = 1'b0;
  logic         fault_en = 1'b0;
  logic [N-1:0] data_in = '0;
  logic [N-1:0] data_out;
  logic         scan_out;

  int n_chk  = 0;
  int n_fail = 0;

  logic       m_arm  [N];
  logic [1:0] m_mode [N];

  always #5ns clk = ~clk;

  sab_chain #(.N_SIG(N)) i_sab_chain (
    .clk      (clk),
    .rst      (rst),
    .scan_in  (scan_in),
    .shift_en (shift_en),
    .update   (update),
    .fault_en (fault_en),
    .data_in  (data_in),
    .data_out (data_out),
    .scan_out (scan_out)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [N-1:0] model(input logic [N-1:0] d, input logic en, input logic rise);
    logic [N-1:0] r = d;
    for (int i = 0; i < N; i++) begin
      if (en && m_arm[i]) begin
        case (m_mode[i])
          2'b01: r[i] = 1'b0;
          2'b10: r[i] = 1'b1;
          2'b11: r[i] = rise ? ~d[i] : d[i];
          default: r[i] = d[i];
        endcase
      end
    end
    return r;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < N; i++) begin
      m_arm[i] = 1'b0;
      m_mode[i] = 2'b00;
    end
  endtask

  // shift the model into the chain, highest cell first
  task automatic load();
    shift_en = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      scan_in = m_arm[i];     step();
      scan_in = m_mode[i][1]; step();
      scan_in = m_mode[i][0]; step();
    end
    shift_en = 1'b0;
    scan_in = 1'b0;
  endtask

  task automatic pulse_update();
    update = 1'b1;
    step();
    update = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    check("R1 data_out after reset", data_out, '0);
    check("R1 scan_out after reset", N'(scan_out), '0);
    fault_en = 1'b1; data_in = 8'hC3;
    step();
    check("R1 cleared config passes", data_out, 8'hC3);
    fault_en = 1'b0;
    step();
  endtask

  task automatic t_readback();
    logic [3*N-1:0] bits;
    clear_model();
    for (int i = 0; i < N; i++) begin
      m_arm[i] = i[0];
      m_mode[i] = 2'(i + 1);
    end
    load();
    for (int i = N - 1; i >= 0; i--)
      bits[3*(N-1-i) +: 3] = {m_mode[i][0], m_mode[i][1], m_arm[i]};
    scan_in = 1'b1;
    repeat (4) step();
    check("R3 scan_out held", N'(scan_out), N'(bits[0]));
    scan_in = 1'b0;
    for (int k = 0; k < 3 * N; k++) begin
      check($sformatf("R2 readback bit %0d", k), N'(scan_out), N'(bits[k]));
      shift_en = 1'b1;
      step();
      shift_en = 1'b0;
    end
    check("R2 chain flushed", N'(scan_out), '0);
  endtask

  task automatic t_passthru();
    clear_model();
    for (int i = 0; i < N; i++) begin m_arm[i] = 1'b1; m_mode[i] = 2'b10; end
    load(); pulse_update();
    fault_en = 1'b0;
    data_in = 8'h5A; step();
    check("R5 enable low 5A", data_out, 8'h5A);
    data_in = 8'h00; step();
    check("R5 enable low 00", data_out, 8'h00);
  endtask

  task automatic t_shadow();
    clear_model();
    for (int i = 0; i < N; i++) begin m_arm[i] = 1'b1; m_mode[i] = 2'b01; end
    fault_en = 1'b1; data_in = 8'hFF;
    load();
    check("R4 shifting leaves outputs (old SA1)", data_out, 8'hFF);
    pulse_update();
    check("R4 update edge output", data_out, 8'hFF);
    step();
    check("R4 new config after update", data_out, 8'h00);
    fault_en = 1'b0; step();
  endtask

  task automatic t_stuck();
    clear_model();
    m_arm[1] = 1'b1; m_mode[1] = 2'b01;
    m_arm[6] = 1'b1; m_mode[6] = 2'b10;
    load(); pulse_update();
    data_in = 8'h0F; fault_en = 1'b1; step();
    check("R7 R8 first enabled cycle", data_out, model(8'h0F, 1'b1, 1'b1));
    data_in = 8'hF0; step();
    check("R7 R8 held cycle", data_out, model(8'hF0, 1'b1, 1'b0));
    data_in = 8'h42; step();
    check("R7 stuck-at-0 bit1", N'(data_out[1]), '0);
    check("R8 stuck-at-1 bit6", N'(data_out[6]), N'(1));
    fault_en = 1'b0; step();
  endtask

  task automatic t_transient();
    clear_model();
    m_arm[3] = 1'b1; m_mode[3] = 2'b11;
    load(); pulse_update();
    data_in = 8'hA5; step();
    check("R9 before rise", data_out, 8'hA5);
    fault_en = 1'b1; step();
    check("R9 flip on rise", data_out, 8'hAD);
    step();
    check("R9 pass after one cycle", data_out, 8'hA5);
    step();
    check("R9 stays pass", data_out, 8'hA5);
    fault_en = 1'b0; step();
    fault_en = 1'b1; data_in = 8'h00; step();
    check("R9 second rise flips again", data_out, 8'h08);
    fault_en = 1'b0; step();
  endtask

  task automatic t_mix();
    clear_model();
    m_arm[0] = 1'b1; m_mode[0] = 2'b10;
    m_arm[1] = 1'b1; m_mode[1] = 2'b01;
    m_arm[2] = 1'b1; m_mode[2] = 2'b11;
    m_arm[3] = 1'b0; m_mode[3] = 2'b10;
    m_arm[4] = 1'b1; m_mode[4] = 2'b00;
    m_arm[5] = 1'b0; m_mode[5] = 2'b01;
    load(); pulse_update();
    data_in = 8'h36; fault_en = 1'b1; step();
    check("R10 mixed cells on rise", data_out, model(8'h36, 1'b1, 1'b1));
    data_in = 8'hC9; step();
    check("R10 mixed cells held", data_out, model(8'hC9, 1'b1, 1'b0));
    check("R6 unarmed and mode 00 pass", N'(data_out[5:3]), N'(3'b001));
    fault_en = 1'b0; step();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_readback();
    t_passthru();
    t_shadow();
    t_stuck();
    t_transient();
    t_mix();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule